// File: doc/BRIEF.md
# Standard Event Status Register

This block keeps the sticky event record of an instrument's remote-control status model, together with an 8-bit enable mask that decides which recorded events may raise a request. Six single-cycle strobes, from the power-up sequencer, the command parser, the command executor and the operation tracker, each set one fixed bit of the record. Bits 6 and 1 have no source, so they always read 0.

A one-bit summary goes high whenever a recorded event also has its enable bit set. This summary drives the event-summary bit of the status byte, and that byte decodes the record through the bit positions listed below. Software reads the record with a strobe that returns the current value and clears it in the same operation. A clear-status strobe also empties the record. The enable mask changes only through its own write strobe.

Top module: `evt_status_reg`

## Requirements
- R1: After reset, the event record, the enable mask and the summary are all 0.
- R2: Each strobe sets its own bit at the next clock edge: power-up sets bit 7, command syntax error sets bit 5, execution error sets bit 4, device-internal fault sets bit 3, query error sets bit 2, and operation complete sets bit 0.
- R3: Bits 6 and 1 of the event record and of the enable mask always read 0.
- R4: A set bit stays 1 after its strobe ends. It clears only on a read strobe or a clear-status strobe.
- R5: While `ev_rd` is high, `ev_rdata` shows the record, and the record is emptied at that edge. An event strobed in the same cycle is kept.
- R6: A clear-status strobe empties the record at the next edge. An event strobed in the same cycle is kept.
- R7: `summary` equals the OR of all bits of (event record AND enable mask). It follows the register state in the same cycle, with no extra latency.
- R8: `en_wr` loads `en_wdata` into the mask at the next edge, with bits 6 and 1 forced to 0. Without `en_wr` the mask holds its value.
- R9: Writing the mask leaves the event record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on_pulse | input | 1 | Power-up event strobe (bit 7) |
| syntax_err_pulse | input | 1 | Command syntax error strobe (bit 5) |
| exec_err_pulse | input | 1 | Execution error strobe (bit 4) |
| dev_err_pulse | input | 1 | Device-internal fault strobe (bit 3) |
| query_err_pulse | input | 1 | Query error strobe (bit 2) |
| op_done_pulse | input | 1 | Armed operation complete strobe (bit 0) |
| ev_rd | input | 1 | Read-and-clear strobe for the event record |
| clr_stb | input | 1 | Clear-status strobe |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write data |
| ev_rdata | output | 8 | Event record value |
| en_rdata | output | 8 | Enable mask value |
| summary | output | 1 | Masked OR of the event record |

## Verification
The hardest situation to reach is a collision: an event strobe lands in the same cycle as a read or a clear-status strobe. Only the new event may survive that edge. Directed steps drive each collision on purpose. Constrained random cycles then overlap strobes, reads, clears and mask writes often enough that these coincidences recur with many different mask values. Every cycle is compared against a reference model kept in the bench.

// File: rtl/evsr_pkg.sv
package evsr_pkg;
  localparam int EV_W = 8;
  localparam int B_PWR = 7;
  localparam int B_SYN = 5;
  localparam int B_EXE = 4;
  localparam int B_DEV = 3;
  localparam int B_QRY = 2;
  localparam int B_OPC = 0;
  localparam logic [EV_W-1:0] IMPL_MASK = 8'b1011_1101;

  function automatic logic [EV_W-1:0] pack_events(logic pwr, logic syn, logic exe,
                                                  logic dev, logic qry, logic opc);
    logic [EV_W-1:0] v;
    v = '0;
    v[B_PWR] = pwr;
    v[B_SYN] = syn;
    v[B_EXE] = exe;
    v[B_DEV] = dev;
    v[B_QRY] = qry;
    v[B_OPC] = opc;
    return v;
  endfunction

  function automatic logic [EV_W-1:0] next_record(logic [EV_W-1:0] cur, logic drop,
                                                  logic [EV_W-1:0] setv);
    return ((drop ? '0 : cur) | setv) & IMPL_MASK;
  endfunction
endpackage

// File: rtl/evsr_latch.sv
module evsr_latch #(
  parameter int W = evsr_pkg::EV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         drop,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= evsr_pkg::next_record(q, drop, set_vec);
  end
endmodule

// File: rtl/evsr_mask.sv
module evsr_mask #(
  parameter int W = evsr_pkg::EV_W,
  parameter logic [W-1:0] KEEP = evsr_pkg::IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata & KEEP;
  end
endmodule

// File: rtl/evsr_summary.sv
module evsr_summary #(
  parameter int W = evsr_pkg::EV_W
) (
  input  logic [W-1:0] ev,
  input  logic [W-1:0] en,
  output logic         hit
);
  logic [W-1:0] masked;
  for (genvar i = 0; i < W; i++) begin : g_and
    assign masked[i] = ev[i] & en[i];
  end
  assign hit = |masked;
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int W = evsr_pkg::EV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_on_pulse,
  input  logic         syntax_err_pulse,
  input  logic         exec_err_pulse,
  input  logic         dev_err_pulse,
  input  logic         query_err_pulse,
  input  logic         op_done_pulse,
  input  logic         ev_rd,
  input  logic         clr_stb,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] ev_rdata,
  output logic [W-1:0] en_rdata,
  output logic         summary
);
  logic [W-1:0] set_vec;
  logic         drop;
  logic [W-1:0] ev_q;
  logic [W-1:0] en_q;

  assign set_vec = evsr_pkg::pack_events(pwr_on_pulse, syntax_err_pulse, exec_err_pulse,
                                         dev_err_pulse, query_err_pulse, op_done_pulse);
  assign drop = ev_rd | clr_stb;

  evsr_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .drop(drop), .q(ev_q)
  );

  evsr_mask #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata), .q(en_q)
  );

  evsr_summary #(.W(W)) u_sum (
    .ev(ev_q), .en(en_q), .hit(summary)
  );

  assign ev_rdata = ev_q;
  assign en_rdata = en_q;
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
  parameter int W = evsr_pkg::EV_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_on_pulse,
  input logic         ev_rd,
  input logic         clr_stb,
  input logic         en_wr,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] ev_rdata,
  input logic [W-1:0] en_rdata,
  input logic         summary
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rdata[6] == 1'b0) && (ev_rdata[1] == 1'b0) && (en_rdata[6] == 1'b0) && (en_rdata[1] == 1'b0)); // R3
  AST_PWR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_pulse |=> ev_rdata[7]); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rd && !clr_stb) |=> ((ev_rdata & $past(ev_rdata)) == $past(ev_rdata))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> (ev_rdata == $past(set_vec))); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (ev_rdata == $past(set_vec))); // R6
  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
    summary == (|(ev_rdata & en_rdata))); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_rdata)); // R8
endmodule

bind evt_status_reg evt_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on_pulse(pwr_on_pulse), .ev_rd(ev_rd),
  .clr_stb(clr_stb), .en_wr(en_wr), .set_vec(set_vec),
  .ev_rdata(ev_rdata), .en_rdata(en_rdata), .summary(summary)
);

// File: tb/evt_status_reg_test.sv
module evt_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pw = 0, sy = 0, ex = 0, de = 0, qy = 0, op = 0, rd = 0, cl = 0, we = 0;
  logic [7:0] wd = '0;
  logic [7:0] ev_rdata, en_rdata;
  logic summary;
  int n_chk = 0, n_bad = 0;
  logic [7:0] ev_m = '0, en_m = '0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_status_reg uut (
    .clk(clk), .rst_n(rst_n), .pwr_on_pulse(pw), .syntax_err_pulse(sy),
    .exec_err_pulse(ex), .dev_err_pulse(de), .query_err_pulse(qy), .op_done_pulse(op),
    .ev_rd(rd), .clr_stb(cl), .en_wr(we), .en_wdata(wd),
    .ev_rdata(ev_rdata), .en_rdata(en_rdata), .summary(summary)
  );

  // Bit map restated independently: 7 pwr, 5 syn, 4 exe, 3 dev, 2 qry, 0 opc.
  function automatic logic [7:0] strobes_to_bits();
    return {pw, 1'b0, sy, ex, de, qy, 1'b0, op};
  endfunction

  function automatic logic [7:0] model_ev(logic [7:0] cur);
    logic [7:0] keep;
    keep = (rd || cl) ? 8'h00 : cur;
    return keep | strobes_to_bits();
  endfunction

  function automatic logic [7:0] model_en(logic [7:0] cur);
    if (!we) return cur;
    return {wd[7], 1'b0, wd[5:2], 1'b0, wd[0]};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic verify(string tag);
    check({tag, " event"}, ev_rdata, ev_m);
    check({tag, " mask"}, en_rdata, en_m);
    check("R7 summary", {7'd0, summary}, {7'd0, |(ev_m & en_m)});
    check("R3 reserved", {ev_rdata[6], ev_rdata[1], en_rdata[6], en_rdata[1]}, 8'h00);
  endtask

  task automatic cyc(string tag, logic [5:0] ev, logic r, logic c, logic w, logic [7:0] d);
    {pw, sy, ex, de, qy, op} = ev;
    rd = r; cl = c; we = w; wd = d;
    @(negedge clk);
    ev_m = model_ev(ev_m);
    en_m = model_en(en_m);
    {pw, sy, ex, de, qy, op} = '0;
    rd = 0; cl = 0; we = 0; wd = '0;
    verify(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    verify("R1 reset");
    // R2: each strobe alone, then read to clear
    for (int i = 0; i < 6; i++) begin
      cyc("R2 set", 6'b100000 >> i, 0, 0, 0, 8'h00);
      cyc("R4 sticky", 6'b0, 0, 0, 0, 8'h00);
      cyc("R5 read", 6'b0, 1, 0, 0, 8'h00);
    end
    // R8: writes to reserved mask bits are dropped
    cyc("R8 mask write", 6'b0, 0, 0, 1, 8'hFF);
    check("R8 mask value", en_rdata, 8'hBD);
    cyc("R8 mask hold", 6'b0, 0, 0, 0, 8'h00);
    // R7: masked event gives no summary, unmasking raises it
    cyc("R7 masked", 6'b000010, 0, 0, 1, 8'h01);
    check("R7 masked summary", {7'd0, summary}, 8'h00);
    cyc("R9 write keeps event", 6'b0, 0, 0, 1, 8'h04);
    check("R9 event kept", ev_rdata, 8'h04);
    check("R7 unmasked summary", {7'd0, summary}, 8'h01);
    // R5: event during read survives
    cyc("R5 read collide", 6'b010000, 1, 0, 0, 8'h00);
    check("R5 collide value", ev_rdata, 8'h20);
    // R6: clear empties, colliding event survives
    cyc("R6 prep", 6'b100001, 0, 0, 0, 8'h00);
    cyc("R6 clear", 6'b0, 0, 1, 0, 8'h00);
    check("R6 empty", ev_rdata, 8'h00);
    cyc("R6 prep2", 6'b001100, 0, 0, 0, 8'h00);
    cyc("R6 clear collide", 6'b000001, 0, 1, 0, 8'h00);
    check("R6 collide value", ev_rdata, 8'h01);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] e;
      for (int b = 0; b < 6; b++) e[b] = ($urandom % 6) == 0;
      cyc("R4 random", e, ($urandom % 7) == 0, ($urandom % 13) == 0,
          ($urandom % 9) == 0, 8'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule